// File: doc/BRIEF.md
# External Trigger Conditioning Path

This block takes a raw, asynchronous trigger pin and turns it into a count strobe for a timer counter. The pin first passes through a two-flop synchroniser. An optional inversion is applied next, so the active transition can be either the rising or the falling edge of the pin. A digital glitch filter follows; it is a separate module instantiated by name. A rising-edge detector then runs on the filtered level, and an edge-counting prescaler lets through one detected edge in every 1, 2, 4 or 8.

Each edge that the prescaler passes produces a strobe exactly one core clock wide, but only while the external count mode is enabled. The timer counter uses the strobe as its increment enable.

Top module: `ext_trig_cond`

## Requirements
- R1: While `rst` is high, and on the first sampled cycle after it is released, `cnt_strobe` is 0 and the prescaler count is cleared.
- R2: With `pol_inv`=0, `div_sel`=00 and `mode_b_en`=1, a pin rise driven just after a clock edge makes `cnt_strobe` high in exactly the FILT_LEN+3rd following clock cycle, and low in every other cycle of that window.
- R3: A pin level that lasts fewer than FILT_LEN clock cycles produces no strobe. A level that lasts FILT_LEN cycles or more is counted as an edge.
- R4: With `pol_inv`=0 the pin's rising edges are counted. With `pol_inv`=1 its falling edges are counted and its rising edges are not.
- R5: `div_sel` sets the ratio: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 8. With ratio N, a strobe is issued on the Nth, 2Nth, ... counted edge after the count was last cleared.
- R6: While `mode_b_en`=0 no strobe is issued, and the prescaler count is held at zero.
- R7: A change of `div_sel` clears the prescaler count.
- R8: Each strobe lasts one clock cycle, and each passed edge gives exactly one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_pin | input | 1 | Asynchronous external trigger pin |
| pol_inv | input | 1 | 0: rising edge active, 1: falling edge active |
| div_sel | input | 2 | Prescaler ratio select: 1, 2, 4 or 8 |
| mode_b_en | input | 1 | Enables count strobes |
| cnt_strobe | output | 1 | One-cycle counter increment strobe |

## Verification
A pin transition reaches `cnt_strobe` after a fixed FILT_LEN+3 clock edges: two synchroniser flops, FILT_LEN filter evaluations and one output register. The latency check drives the pin on a falling clock edge and samples the strobe on each following falling edge, so the expected cycle is counted exactly. The random and counting checks hold every pin level long enough for the filter to accept it. Before comparing the number of strobes with the number of active edges divided by the ratio, they wait more than FILT_LEN+3 cycles for the pipeline to drain. Configuration is changed only while the mode is disabled and the pin is idle, so no edge is in flight when a setting changes.

// File: rtl/etc_pkg.sv
package etc_pkg;
  localparam int DIV_W = 2;
  localparam int PCNT_W = (1 << DIV_W) - 1;

  // all-ones mask of width div: ratio minus one
  function automatic logic [PCNT_W-1:0] ratio_mask(input logic [DIV_W-1:0] d);
    logic [PCNT_W-1:0] m;
    m = '0;
    for (int i = 0; i < PCNT_W; i++)
      if (i < int'(d)) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/etc_sync.sv
module etc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/etc_filter.sv
module etc_filter #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_in,
  output logic lvl_out
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] run;
  logic          held;

  // the output follows the input only after LEN consecutive differing samples
  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= '0;
      held <= 1'b0;
    end else if (lvl_in == held) begin
      run <= '0;
    end else if (run == LAST) begin
      run  <= '0;
      held <= lvl_in;
    end else begin
      run <= run + 1'b1;
    end
  end

  assign lvl_out = held;
endmodule

// File: rtl/etc_edge.sv
module etc_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/etc_prescale.sv
module etc_prescale
  import etc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_in,
  input  logic [DIV_W-1:0] div,
  input  logic             en,
  output logic             strobe
);
  logic [PCNT_W-1:0] cnt;
  logic [DIV_W-1:0]  div_q;
  logic [PCNT_W-1:0] mask;

  assign mask = ratio_mask(div);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      div_q  <= '0;
      strobe <= 1'b0;
    end else begin
      div_q  <= div;
      strobe <= 1'b0;
      if (!en || (div != div_q)) begin
        cnt <= '0;
      end else if (edge_in) begin
        if (cnt == mask) begin
          cnt    <= '0;
          strobe <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ext_trig_cond.sv
module ext_trig_cond
  import etc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_pin,
  input  logic             pol_inv,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             mode_b_en,
  output logic             cnt_strobe
);
  logic pin_s;
  logic pin_pol;
  logic filt_lvl;
  logic edge_rise;

  etc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (trig_pin),
    .q_sync  (pin_s)
  );

  assign pin_pol = pin_s ^ pol_inv;

  etc_filter #(.LEN(FILT_LEN)) u_filt (
    .clk     (clk),
    .rst     (rst),
    .lvl_in  (pin_pol),
    .lvl_out (filt_lvl)
  );

  etc_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (filt_lvl),
    .rise (edge_rise)
  );

  etc_prescale u_psc (
    .clk     (clk),
    .rst     (rst),
    .edge_in (edge_rise),
    .div     (div_sel),
    .en      (mode_b_en),
    .strobe  (cnt_strobe)
  );
endmodule

// File: rtl/ext_trig_cond_chk.sv
module ext_trig_cond_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [1:0] div,
  input logic       filt,
  input logic       rise,
  input logic       strobe
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> !strobe);

  // R6
  disabled_silent_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !strobe);

  // R8
  single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);

  // R8
  strobe_from_level_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |-> $past(filt));

  // R5
  div1_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && en && div == 2'b00 && $past(div) == 2'b00) |=> strobe);
endmodule

bind ext_trig_cond ext_trig_cond_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .en     (mode_b_en),
  .div    (div_sel),
  .filt   (filt_lvl),
  .rise   (edge_rise),
  .strobe (cnt_strobe)
);

// File: tb/tb_ext_trig_cond.sv
module tb_ext_trig_cond;
  localparam int FL = 3;
  localparam int LAT = FL + 3;

  logic       clk = 0;
  logic       rst = 1;
  logic       trig_pin = 0;
  logic       pol_inv = 0;
  logic [1:0] div_sel = 0;
  logic       mode_b_en = 0;
  logic       cnt_strobe;

  int checks = 0;
  int fails = 0;
  int seen = 0;
  int active = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ext_trig_cond #(.FILT_LEN(FL)) dut (
    .clk(clk), .rst(rst), .trig_pin(trig_pin), .pol_inv(pol_inv),
    .div_sel(div_sel), .mode_b_en(mode_b_en), .cnt_strobe(cnt_strobe)
  );

  logic prev_s = 0;
  always @(negedge clk) begin
    if (cnt_strobe) seen++;
    if (!rst && cnt_strobe && prev_s) begin
      checks++; fails++;
      $display("FAIL R8: strobe wide, got 1 expected 0");
    end
    prev_s <= cnt_strobe;
  end

  function automatic int expect_cnt(int edges, logic [1:0] d);
    return edges >> d;
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic hold(logic v, int n);
    @(negedge clk);
    if (v != trig_pin && mode_b_en && (v ^ pol_inv)) active++;
    trig_pin = v;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic setup(logic p, logic [1:0] d);
    @(negedge clk);
    mode_b_en = 0;
    repeat (LAT + 4) @(negedge clk);
    pol_inv = p;
    div_sel = d;
    repeat (LAT + 4) @(negedge clk);
    mode_b_en = 1;
    active = 0;
    seen = 0;
  endtask

  task automatic pulses(int n, int wmin);
    for (int i = 0; i < n; i++) begin
      hold(~trig_pin, wmin + int'($urandom_range(0, 4)));
      hold(~trig_pin, wmin + int'($urandom_range(0, 4)));
    end
    repeat (LAT + 4) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: held in reset
    chk("R1", int'(cnt_strobe), 0);
    rst = 0;
    @(negedge clk);
    chk("R1", int'(cnt_strobe), 0);

    // R2: exact latency
    setup(0, 2'b00);
    @(negedge clk);
    trig_pin = 1;
    for (int i = 1; i <= LAT + 4; i++) begin
      @(negedge clk);
      chk("R2", int'(cnt_strobe), (i == LAT) ? 1 : 0);
    end
    hold(0, FL + 4);
    repeat (LAT) @(negedge clk);

    // R3: short glitch ignored, minimum width accepted
    seen = 0;
    hold(1, FL - 1);
    hold(0, FL + 6);
    repeat (LAT) @(negedge clk);
    chk("R3", seen, 0);
    hold(1, FL);
    hold(0, FL + 6);
    repeat (LAT) @(negedge clk);
    chk("R3", seen, 1);

    // R4: falling edges with inversion
    setup(1, 2'b00);
    hold(1, FL + 2);
    repeat (LAT + 2) @(negedge clk);
    chk("R4", seen, 0);
    hold(0, FL + 2);
    repeat (LAT + 2) @(negedge clk);
    chk("R4", seen, 1);

    // R5: each ratio, directed
    for (int d = 0; d < 4; d++) begin
      setup(0, 2'(d));
      pulses(9, FL);
      chk("R5", seen, expect_cnt(active, 2'(d)));
    end

    // R6: disabled gives nothing
    setup(0, 2'b00);
    mode_b_en = 0;
    pulses(5, FL);
    chk("R6", seen, 0);
    // R6: disable clears count
    setup(0, 2'b11);
    pulses(3, FL);
    setup(0, 2'b11);
    pulses(5, FL);
    chk("R6", seen, 0);

    // R7: divide change clears count
    setup(0, 2'b10);
    pulses(3, FL);
    @(negedge clk);
    div_sel = 2'b01;
    repeat (3) @(negedge clk);
    seen = 0;
    pulses(2, FL);
    chk("R7", seen, 1);

    // R4 R5 random segments
    for (int s = 0; s < 12; s++) begin
      logic p;
      logic [1:0] d;
      p = 1'($urandom_range(0, 1));
      d = 2'($urandom_range(0, 3));
      setup(p, d);
      pulses(int'($urandom_range(4, 20)), FL);
      chk(p ? "R4" : "R5", seen, expect_cnt(active, d));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule